// File: doc/BRIEF.md
# PCIe Interrupt Collector with Legacy/MSI Signalling

This block gathers up to sixteen local interrupt request lines, together with bits that software sets through a mailbox register, into a sticky interrupt status register. The status register is masked by an enable register. The result drives a single upstream interrupt toward the PCIe link. The interrupt leaves the block in one of two forms. The first is a level on a legacy interrupt pin, which stays asserted while any enabled status bit is set. The second is a one-cycle message request toward a message-signalled interrupt generator, which must acknowledge it before another request is issued.

The signalling mode follows two configuration-space control bits that arrive as inputs: the command register's interrupt-disable bit and the message-interrupt enable bit. Software changes mode by enabling the new scheme before it disables the old one. The block gives message signalling precedence whenever both schemes appear enabled. Entering message mode while an enabled request is already pending produces a message request, so no request is lost during the switch.

A simple register port gives software access to the status, enable and mailbox registers. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `pcie_irq_gen`

## Requirements
- R1: A high level on local input `irq_in[i]` sampled at a clock edge sets bit i of the status register, which reads back at offset 0x40 (bits 15:0, upper bits read 0).
- R2: A register write to the mailbox offset 0x60 sets every status bit whose corresponding write-data bit is 1 and leaves the others unchanged.
- R3: Status bits are sticky. A write to offset 0x40 clears exactly the bits written as 1; bits written as 0 keep their value.
- R4: When a set event (local input or mailbox) and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R5: The enable register at offset 0x50 is read/write in bits 15:0 and resets to 0; bits 31:16 read 0 regardless of what is written.
- R6: When `cfg_msi_en` is 0 and `cfg_intx_dis` is 0, `intx_out` equals the OR of (status AND enable). In every other configuration it is 0.
- R7: When `cfg_msi_en` is 1, `intx_out` is 0 even if `cfg_intx_dis` is 0. Message signalling takes precedence.
- R8: In message mode, a rise of (status AND enable) from all-zero to non-zero produces a `msi_req` pulse one cycle wide, asserted after the clock edge that follows the edge on which the status bit was set. A pending set that stays high produces no further pulse.
- R9: After a `msi_req` pulse, no further pulse is issued until `msi_ack` is sampled high. A rise that occurs while waiting is remembered and issued on the second edge after the acknowledge.
- R10: Setting `cfg_msi_en` while an enabled status bit is already pending produces a `msi_req` pulse on the next clock edge, so the request survives a legacy-to-message switch.
- R11: After reset the status register and enable register are 0, and `intx_out` and `msi_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Local interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cfg_intx_dis | input | 1 | Command register interrupt-disable bit |
| cfg_msi_en | input | 1 | Message-interrupt enable bit |
| intx_out | output | 1 | Legacy interrupt level |
| msi_req | output | 1 | Message interrupt request pulse |
| msi_ack | input | 1 | Acknowledge from the message generator |

## Verification
On every cycle, the assertions check four things: status bits stay sticky unless a write clears them, a set wins over a clear, the legacy level never coexists with message mode or with the interrupt-disable bit, and no message request is issued while an earlier one is unacknowledged. The bench scenarios cover the behaviour that depends on ordering and on values:

- the full sweep of every enable bit against every mailbox bit for the legacy level;
- the exact cycle on which a message request appears;
- a remembered rise being delivered only after the acknowledge;
- a pending request surviving the overlap when software switches from legacy to message signalling.

// File: rtl/pcie_irq_pkg.sv
// Package: shared offsets and the signalling mode type for the interrupt collector.
// Assumes byte offsets fit the register port address width used by the top.
package pcie_irq_pkg;
    localparam logic [7:0] OFS_STATUS  = 8'h40;
    localparam logic [7:0] OFS_ENABLE  = 8'h50;
    localparam logic [7:0] OFS_MAILBOX = 8'h60;

    typedef enum logic [1:0] {
        SIG_OFF    = 2'd0,
        SIG_LEGACY = 2'd1,
        SIG_MSI    = 2'd2
    } sig_mode_e;
endpackage

// File: rtl/irq_reg_port.sv
// Module: register port decode. Holds the enable register, turns writes into
// clear and mailbox-set masks for the status register, and muxes read data.
// Assumes NUM_IRQ <= DATA_W and single-cycle write strobes.
module irq_reg_port
    import pcie_irq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_IRQ-1:0] status,
    output logic [NUM_IRQ-1:0] enable,
    output logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] mbox_mask
);
    logic hit_status, hit_enable, hit_mbox;

    // Address decode for the three registers.
    always_comb begin
        hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
        hit_enable = (reg_addr == ADDR_W'(OFS_ENABLE));
        hit_mbox   = (reg_addr == ADDR_W'(OFS_MAILBOX));
    end

    // Write-derived masks handed to the status register.
    always_comb begin
        clr_mask  = (reg_wr && hit_status) ? reg_wdata[NUM_IRQ-1:0] : '0;
        mbox_mask = (reg_wr && hit_mbox)   ? reg_wdata[NUM_IRQ-1:0] : '0;
    end

    // Enable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (reg_wr && hit_enable) begin
            enable <= reg_wdata[NUM_IRQ-1:0];
        end
    end

    // Read data mux; unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_status) begin
            reg_rdata[NUM_IRQ-1:0] = status;
        end else if (hit_enable) begin
            reg_rdata[NUM_IRQ-1:0] = enable;
        end
    end

    // R5: enable only changes through a write to its offset.
    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_enable) |=> $stable(enable));
endmodule

// File: rtl/irq_status_reg.sv
// Module: sticky interrupt status register. Local inputs and mailbox bits set
// bits; write-1 masks clear them; a set in the same cycle beats a clear.
// Assumes the masks are valid for exactly the cycle they apply.
module irq_status_reg #(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] mbox_mask,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] status
);
    logic [NUM_IRQ-1:0] set_mask;

    // Combine the two set sources.
    always_comb set_mask = irq_in | mbox_mask;

    // Per-bit status update, set priority over clear.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (set_mask[i]) begin
                status[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                status[i] <= 1'b0;
            end
        end
    end

    // R3: a set bit only falls when a clear was written to it.
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr_mask) & ~status) == '0));

    // R4: anything set last cycle is set now, whatever was cleared.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_mask) & ~status) == '0));
endmodule

// File: rtl/irq_signal_sel.sv
// Module: chooses legacy or message signalling from configuration bits and
// drives the legacy level or the message request/acknowledge handshake.
// Assumes msi_ack arrives only after a request; a stray ack is harmless.
module irq_signal_sel
    import pcie_irq_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] status,
    input  logic [NUM_IRQ-1:0] enable,
    input  logic               cfg_intx_dis,
    input  logic               cfg_msi_en,
    input  logic               msi_ack,
    output logic               intx_out,
    output logic               msi_req
);
    sig_mode_e mode;
    logic      pending;
    logic      msi_live, msi_live_q;
    logic      trig;
    logic      busy, owed;

    // Mode select: message signalling wins over legacy.
    always_comb begin
        if (cfg_msi_en)         mode = SIG_MSI;
        else if (!cfg_intx_dis) mode = SIG_LEGACY;
        else                    mode = SIG_OFF;
    end

    // Masked pending summary and the message-mode rise detector.
    always_comb begin
        pending  = |(status & enable);
        msi_live = (mode == SIG_MSI) && pending;
        trig     = msi_live && !msi_live_q;
    end

    // Legacy level output.
    always_comb intx_out = (mode == SIG_LEGACY) && pending;

    // Message request pulse, outstanding flag and remembered rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_live_q <= 1'b0;
            msi_req    <= 1'b0;
            busy       <= 1'b0;
            owed       <= 1'b0;
        end else begin
            msi_live_q <= msi_live;
            msi_req    <= 1'b0;
            if (msi_ack) busy <= 1'b0;
            if ((trig || owed) && !busy) begin
                msi_req <= 1'b1;
                busy    <= 1'b1;
                owed    <= 1'b0;
            end else if (trig) begin
                owed <= 1'b1;
            end
            if (mode != SIG_MSI) owed <= 1'b0;
        end
    end

    // R6: the legacy level is never driven with interrupts disabled.
    p_intx_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        intx_out |-> !cfg_intx_dis);

    // R7: legacy level and message mode never coexist.
    p_msi_precedence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_msi_en |-> !intx_out);

    // R8: a request is a single-cycle pulse.
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |=> !msi_req);

    // R9: no new request while the previous one is unacknowledged.
    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !msi_ack) |=> !msi_req);
endmodule

// File: rtl/pcie_irq_gen.sv
// Module: top of the PCIe interrupt collector. Wires the register port, the
// sticky status register and the legacy/message signalling selector.
// Assumes a single clock domain; configuration bits are already synchronous.
module pcie_irq_gen
    import pcie_irq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               cfg_intx_dis,
    input  logic               cfg_msi_en,
    output logic               intx_out,
    output logic               msi_req,
    input  logic               msi_ack
);
    logic [NUM_IRQ-1:0] status, enable, clr_mask, mbox_mask;

    irq_reg_port #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status    (status),
        .enable    (enable),
        .clr_mask  (clr_mask),
        .mbox_mask (mbox_mask)
    );

    irq_status_reg #(.NUM_IRQ(NUM_IRQ)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .mbox_mask (mbox_mask),
        .clr_mask  (clr_mask),
        .status    (status)
    );

    irq_signal_sel #(.NUM_IRQ(NUM_IRQ)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .status       (status),
        .enable       (enable),
        .cfg_intx_dis (cfg_intx_dis),
        .cfg_msi_en   (cfg_msi_en),
        .msi_ack      (msi_ack),
        .intx_out     (intx_out),
        .msi_req      (msi_req)
    );

    // R11: while held in reset, outputs reach zero on the next edge.
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!msi_req && status == '0 && enable == '0));
endmodule

// File: tb/pcie_irq_gen_test.sv
// Bench: sweeps single-bit set/clear, enable-by-mailbox combinations and the
// message handshake, with expected values worked out in the bench.
module pcie_irq_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cfg_intx_dis, cfg_msi_en;
    logic        intx_out, msi_req, msi_ack;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pcie_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_intx_dis(cfg_intx_dis), .cfg_msi_en(cfg_msi_en),
        .intx_out(intx_out), .msi_req(msi_req), .msi_ack(msi_ack)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ack();
        msi_ack = 1'b1;
        step();
        msi_ack = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        cfg_intx_dis = 1'b0; cfg_msi_en = 1'b0; msi_ack = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R11 reset state
        rd(8'h40, v); chk(v, 32'h0, "R11 status after reset");
        rd(8'h50, v); chk(v, 32'h0, "R11 enable after reset");
        chk({31'd0, intx_out}, 32'd0, "R11 intx after reset");
        chk({31'd0, msi_req}, 32'd0, "R11 msi_req after reset");

        // R5 enable read/write, upper bits zero
        wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, v); chk(v, 32'h0000_FFFF, "R5 enable all ones");
        wr(8'h50, 32'h1234_A5C3); rd(8'h50, v); chk(v, 32'h0000_A5C3, "R5 enable pattern");
        wr(8'h50, 32'h0);         rd(8'h50, v); chk(v, 32'h0, "R5 enable cleared");

        // R1 and R3 sweep over local inputs
        for (int i = 0; i < 16; i++) begin
            irq_in = 16'(1 << i);
            step();
            irq_in = '0;
            rd(8'h40, v); chk(v, 32'(1 << i), "R1 local input sets bit");
            wr(8'h40, 32'h0); rd(8'h40, v); chk(v, 32'(1 << i), "R3 zero write keeps bit");
            wr(8'h40, 32'(1 << i)); rd(8'h40, v); chk(v, 32'h0, "R3 write-1 clears bit");
        end

        // R2 and R6 sweep: every enable bit against every mailbox bit, legacy mode
        for (int e = 0; e < 16; e++) begin
            wr(8'h50, 32'(1 << e));
            for (int m = 0; m < 16; m++) begin
                wr(8'h60, 32'(1 << m));
                rd(8'h40, v); chk(v, 32'(1 << m), "R2 mailbox sets bit");
                chk({31'd0, intx_out}, (e == m) ? 32'd1 : 32'd0, "R6 legacy level");
                wr(8'h40, 32'(1 << m));
                chk({31'd0, intx_out}, 32'd0, "R6 legacy drops after clear");
            end
        end

        // R4 set beats clear in the same cycle
        irq_in = 16'h0008;
        wr(8'h40, 32'h0000_0008);
        irq_in = '0;
        rd(8'h40, v); chk(v, 32'h0000_0008, "R4 set wins over clear");
        wr(8'h60, 32'h0000_0100);
        reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0000_0100;
        step(); reg_wr = 1'b0;
        rd(8'h40, v); chk(v, 32'h0000_0108, "R2 mailbox leaves other bits");
        wr(8'h40, 32'h0000_FFFF);
        rd(8'h40, v); chk(v, 32'h0, "R3 clear all");

        // R6 interrupt-disable gates legacy level
        wr(8'h50, 32'h0000_0001);
        wr(8'h60, 32'h0000_0001);
        chk({31'd0, intx_out}, 32'd1, "R6 legacy asserted");
        cfg_intx_dis = 1'b1; #1;
        chk({31'd0, intx_out}, 32'd0, "R6 disable bit gates legacy");
        cfg_intx_dis = 1'b0; #1;
        chk({31'd0, intx_out}, 32'd1, "R6 legacy back");

        // R7 and R10 legacy to message switch with a pending request
        cfg_msi_en = 1'b1; #1;
        chk({31'd0, intx_out}, 32'd0, "R7 message mode wins");
        chk({31'd0, msi_req}, 32'd0, "R10 no pulse before edge");
        step();
        chk({31'd0, msi_req}, 32'd1, "R10 pending survives switch");
        cfg_intx_dis = 1'b1;
        step();
        chk({31'd0, msi_req}, 32'd0, "R8 pulse one cycle");
        ack();
        repeat (3) step();
        chk({31'd0, msi_req}, 32'd0, "R8 steady pending no new pulse");

        // R8 rise timing in message mode
        wr(8'h40, 32'h0000_0001);
        step();
        wr(8'h60, 32'h0000_0001);
        chk({31'd0, msi_req}, 32'd0, "R8 no pulse on set edge");
        step();
        chk({31'd0, msi_req}, 32'd1, "R8 pulse after next edge");
        step();
        chk({31'd0, msi_req}, 32'd0, "R8 pulse ends");

        // R9 rise while waiting for ack is held until after ack
        wr(8'h40, 32'h0000_0001);
        step();
        irq_in = 16'h0001;
        step();
        irq_in = '0;
        for (int k = 0; k < 4; k++) begin
            chk({31'd0, msi_req}, 32'd0, "R9 held while unacknowledged");
            step();
        end
        ack();
        chk({31'd0, msi_req}, 32'd0, "R9 not on ack edge");
        step();
        chk({31'd0, msi_req}, 32'd1, "R9 remembered rise issued");
        step();
        chk({31'd0, msi_req}, 32'd0, "R9 single pulse");
        ack();

        // R11 reset clears state mid-run
        rst_n = 1'b0; step(); rst_n = 1'b1;
        rd(8'h40, v); chk(v, 32'h0, "R11 status cleared by reset");
        rd(8'h50, v); chk(v, 32'h0, "R11 enable cleared by reset");

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule